// File: doc/BRIEF.md
# Byte-Permutation Keystream Generator

This block produces the keystream of the classic byte-swap stream cipher (the 256-entry permutation cipher widely used in older wireless and transport security). A host writes the key bytes into an internal key table through a simple write port, presents the key length and pulses `start`. The engine then runs three phases:

- it fills the state table with the identity permutation;
- it runs the full key schedule;
- it delivers keystream bytes one at a time on a valid/ready output.

The outer logic XORs each keystream byte with data, so the same engine serves both encryption and decryption.

Both tables are single-port byte memories with one cycle of read latency, held as register arrays. Every swap is therefore done as a fixed sequence of single memory accesses, with two holding registers carrying the entries being exchanged. Any new key needs a fresh `start`, which repeats the fill and the key schedule before the first byte appears.

The output follows valid/ready rules. A byte is transferred on a clock edge where both `ks_valid` and `ks_ready` are high. While `ks_valid` is high and `ks_ready` is low, the byte and its valid flag hold unchanged and the engine does no further work. The next byte is computed only after a transfer.

Top module: `kstream_gen`

## Requirements
- R1: After reset, and after any accepted `start`, `ks_valid` stays low until the fill and the full key schedule for that key have completed.
- R2: Key bytes are written at addresses 0 to len-1 with `key_we`. `key_len` (1 to 256) is sampled when `start` is accepted. The key is applied cyclically, so table entry n uses key byte n mod len.
- R3: The output bytes equal the standard cipher keystream. The counters i and j are cleared after the schedule, so the first byte uses i = 1. For example, the key 01 02 03 04 05 yields B2 39 63 05 as its first bytes.
- R4: While `ks_valid` is high and `ks_ready` is low, `ks_valid` stays high and `ks_data` stays stable. Exactly one byte is delivered per transfer.
- R5: Writes on the key port during the fill or the key schedule are ignored.
- R6: A `start` pulse during the fill or the key schedule is ignored, together with the `key_len` value present at that time.
- R7: A `start` in the idle state or during keystream generation begins a full re-initialisation. `ks_valid` is low in the following cycle, and the stream restarts from the first byte of the new key.
- R8: The key schedule never begins before all 256 state entries have been written with their identity values.
- R9: Key lengths of 1 and 256 bytes produce the correct keystream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_we | input | 1 | Key table write strobe (honoured when idle or generating) |
| key_addr | input | 8 | Key table write address |
| key_data | input | 8 | Key byte to write |
| key_len | input | 9 | Key length in bytes, 1 to 256, sampled at start |
| start | input | 1 | Begin fill and key schedule for the loaded key |
| ks_data | output | 8 | Keystream byte |
| ks_valid | output | 1 | Keystream byte available |
| ks_ready | input | 1 | Downstream accepts the keystream byte |

## Verification
The assertions assume that `key_len` lies between 1 and 256 whenever `start` is accepted. The length-range check relies on that assumption. They also assume that `start` is a single-cycle pulse: the stall-hold property excludes cycles where a restart is requested. The stimulus only ever uses lengths of 1, 3, 4, 5, 6 and 256, and drives every pulse for exactly one cycle at the falling edge. Writes and starts that land during the busy phases are placed deliberately in the middle of the key schedule, where accepting them would visibly change the stream.

// File: rtl/kstream_pkg.sv
package kstream_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_FILLK,
    ST_RDI,
    ST_CJ,
    ST_LJ,
    ST_RDJ,
    ST_CAPJ,
    ST_WRI,
    ST_WRJ,
    ST_NEXTI,
    ST_RDT,
    ST_CAPT,
    ST_OUT
  } ctl_state_t;
endpackage

// File: rtl/kstream_mem.sv
module kstream_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, registered read: data appears one cycle after the address
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/kstream_ctrl.sv
module kstream_ctrl
  import kstream_pkg::*;
#(
  parameter int AW = 8,
  parameter int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] key_len,
  input  logic          key_we,
  input  logic [AW-1:0] key_addr,
  input  logic [AW-1:0] key_data,
  output logic [AW-1:0] ks_data,
  output logic          ks_valid,
  input  logic          ks_ready,
  output logic          s_we,
  output logic [AW-1:0] s_addr,
  output logic [AW-1:0] s_wdata,
  input  logic [AW-1:0] s_rdata,
  output logic          k_we,
  output logic [AW-1:0] k_addr,
  output logic [AW-1:0] k_wdata,
  input  logic [AW-1:0] k_rdata
);
  localparam logic [AW-1:0] IDX_MAX = '1;
  localparam int DEPTH = 1 << AW;
  localparam logic [LW-1:0] LEN_MAX = LW'(DEPTH);

  ctl_state_t    state;
  logic [AW-1:0] idx_i, idx_j, si_h, sj_h, jsum, tsum, out_q;
  logic [LW-1:0] len_q;
  logic          gen_phase, fill_done;
  logic          host_ok, restart;

  assign host_ok  = (state == ST_IDLE) || gen_phase;
  assign restart  = start && host_ok;
  assign ks_valid = (state == ST_OUT);
  assign ks_data  = out_q;

  always_comb begin
    s_we    = 1'b0;
    s_addr  = idx_i;
    s_wdata = idx_i;
    k_we    = 1'b0;
    k_addr  = idx_i;
    k_wdata = k_rdata;
    if (host_ok) begin
      k_we    = key_we;
      k_addr  = key_addr;
      k_wdata = key_data;
    end
    case (state)
      ST_FILL: begin
        s_we   = 1'b1;
        k_addr = idx_i - len_q[AW-1:0];
      end
      ST_FILLK: k_we = 1'b1;
      ST_RDJ, ST_CAPJ: s_addr = idx_j;
      ST_WRI: begin
        s_we    = 1'b1;
        s_wdata = sj_h;
      end
      ST_WRJ: begin
        s_we    = 1'b1;
        s_addr  = idx_j;
        s_wdata = si_h;
      end
      ST_RDT: s_addr = tsum;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx_i     <= '0;
      idx_j     <= '0;
      si_h      <= '0;
      sj_h      <= '0;
      jsum      <= '0;
      tsum      <= '0;
      out_q     <= '0;
      len_q     <= LW'(1);
      gen_phase <= 1'b0;
      fill_done <= 1'b0;
    end else if (restart) begin
      state     <= ST_FILL;
      idx_i     <= '0;
      idx_j     <= '0;
      len_q     <= key_len;
      gen_phase <= 1'b0;
      fill_done <= 1'b0;
    end else begin
      case (state)
        ST_FILL: begin
          if ({1'b0, idx_i} >= len_q) state <= ST_FILLK;
          else if (idx_i == IDX_MAX) begin
            state <= ST_RDI; idx_i <= '0; idx_j <= '0; fill_done <= 1'b1;
          end else idx_i <= idx_i + 1'b1;
        end
        ST_FILLK: begin
          if (idx_i == IDX_MAX) begin
            state <= ST_RDI; idx_i <= '0; idx_j <= '0; fill_done <= 1'b1;
          end else begin
            state <= ST_FILL; idx_i <= idx_i + 1'b1;
          end
        end
        ST_RDI: state <= ST_CJ;
        ST_CJ: begin
          si_h  <= s_rdata;
          jsum  <= idx_j + s_rdata + (gen_phase ? '0 : k_rdata);
          state <= ST_LJ;
        end
        ST_LJ: begin
          idx_j <= jsum;
          state <= ST_RDJ;
        end
        ST_RDJ: state <= ST_CAPJ;
        ST_CAPJ: begin
          sj_h  <= s_rdata;
          state <= ST_WRI;
        end
        ST_WRI: state <= ST_WRJ;
        ST_WRJ: begin
          if (gen_phase) begin
            tsum  <= si_h + sj_h;
            state <= ST_RDT;
          end else if (idx_i == IDX_MAX) begin
            gen_phase <= 1'b1;
            idx_i <= '0; idx_j <= '0;
            state <= ST_NEXTI;
          end else begin
            idx_i <= idx_i + 1'b1;
            state <= ST_RDI;
          end
        end
        ST_NEXTI: begin
          idx_i <= idx_i + 1'b1;
          state <= ST_RDI;
        end
        ST_RDT: state <= ST_CAPT;
        ST_CAPT: begin
          out_q <= s_rdata;
          state <= ST_OUT;
        end
        ST_OUT: if (ks_ready) state <= ST_NEXTI;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ks_ready && !start) |=> (ks_valid && $stable(ks_data)));

  // R7
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!ks_valid && !gen_phase && state == ST_FILL));

  // R8
  fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && state != ST_FILL && state != ST_FILLK) |-> fill_done);

  // R1
  valid_after_sched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |-> (gen_phase && fill_done));

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (len_q != '0 && len_q <= LEN_MAX));
endmodule

// File: rtl/kstream_gen.sv
module kstream_gen #(
  parameter int AW = 8,
  parameter int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic [AW-1:0] key_addr,
  input  logic [AW-1:0] key_data,
  input  logic [LW-1:0] key_len,
  input  logic          start,
  output logic [AW-1:0] ks_data,
  output logic          ks_valid,
  input  logic          ks_ready
);
  logic          s_we, k_we;
  logic [AW-1:0] s_addr, s_wdata, s_rdata;
  logic [AW-1:0] k_addr, k_wdata, k_rdata;

  kstream_mem #(.AW(AW), .DW(AW)) u_smem (
    .clk(clk), .we(s_we), .addr(s_addr), .wdata(s_wdata), .rdata(s_rdata)
  );

  kstream_mem #(.AW(AW), .DW(AW)) u_kmem (
    .clk(clk), .we(k_we), .addr(k_addr), .wdata(k_wdata), .rdata(k_rdata)
  );

  kstream_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len),
    .key_we(key_we), .key_addr(key_addr), .key_data(key_data),
    .ks_data(ks_data), .ks_valid(ks_valid), .ks_ready(ks_ready),
    .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .k_we(k_we), .k_addr(k_addr), .k_wdata(k_wdata), .k_rdata(k_rdata)
  );
endmodule

// File: tb/kstream_gen_bench.sv
`timescale 1ns/1ps
module kstream_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_we = 1'b0;
  logic [7:0] key_addr = '0;
  logic [7:0] key_data = '0;
  logic [8:0] key_len = 9'd1;
  logic       start = 1'b0;
  logic [7:0] ks_data;
  logic       ks_valid;
  logic       ks_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] kbuf [256];
  logic [7:0] model_out [64];

  localparam int NV = 4;
  localparam int VLEN [NV] = '{5, 3, 4, 6};
  localparam logic [63:0] VKEY [NV] = '{
    64'h0102030405000000, 64'h4B65790000000000,
    64'h57696B6900000000, 64'h5365637265740000};
  localparam logic [31:0] VEXP [NV] = '{
    32'hB2396305, 32'hEB9F7781, 32'h6044DB6D, 32'h04D46B05};

  kstream_gen u_kstream_gen (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_addr(key_addr),
    .key_data(key_data), .key_len(key_len), .start(start),
    .ks_data(ks_data), .ks_valid(ks_valid), .ks_ready(ks_ready)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ref_stream(input int len, input int n);
    logic [7:0] s [256];
    logic [7:0] tmp;
    int i, j, t;
    for (int a = 0; a < 256; a++) s[a] = a[7:0];
    j = 0;
    for (int a = 0; a < 256; a++) begin
      j = (j + int'(s[a]) + int'(kbuf[a % len])) % 256;
      tmp = s[a]; s[a] = s[j]; s[j] = tmp;
    end
    i = 0; j = 0;
    for (int b = 0; b < n; b++) begin
      i = (i + 1) % 256;
      j = (j + int'(s[i])) % 256;
      tmp = s[i]; s[i] = s[j]; s[j] = tmp;
      t = (int'(s[i]) + int'(s[j])) % 256;
      model_out[b] = s[t];
    end
  endtask

  task automatic write_key(input int len);
    for (int a = 0; a < len; a++) begin
      @(negedge clk);
      key_we = 1'b1; key_addr = a[7:0]; key_data = kbuf[a];
    end
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk);
    key_len = len[8:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b);
    b = 8'hxx;
    for (int w = 0; w < 8000; w++) begin
      @(negedge clk);
      if (ks_valid) begin
        b = ks_data;
        return;
      end
    end
  endtask

  initial begin
    logic [7:0] b;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 reset valid", {31'd0, ks_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 idle valid", {31'd0, ks_valid}, 32'd0);

    // R2 R3 R8: known vectors, walked by one loop
    for (int v = 0; v < NV; v++) begin
      for (int a = 0; a < 8; a++) kbuf[a] = VKEY[v][63 - 8*a -: 8];
      write_key(VLEN[v]);
      pulse_start(VLEN[v]);
      for (int n = 0; n < 4; n++) begin
        get_byte(b);
        chk($sformatf("R3 vector %0d byte %0d", v, n), {24'd0, b},
            {24'd0, VEXP[v][31 - 8*n -: 8]});
      end
    end

    // R3: longer run against the bench model (key 01..05)
    for (int a = 0; a < 5; a++) kbuf[a] = 8'(a + 1);
    write_key(5);
    pulse_start(5);
    ref_stream(5, 40);
    for (int n = 0; n < 40; n++) begin
      get_byte(b);
      chk($sformatf("R3 long byte %0d", n), {24'd0, b}, {24'd0, model_out[n]});
    end

    // R4: back-pressure holds byte and valid
    ks_ready = 1'b0;
    pulse_start(5);
    get_byte(b);
    for (int w = 0; w < 5; w++) begin
      @(negedge clk);
      chk("R4 stall valid", {31'd0, ks_valid}, 32'd1);
      chk("R4 stall data", {24'd0, ks_data}, {24'd0, b});
    end
    chk("R4 first byte", {24'd0, b}, {24'd0, model_out[0]});
    ks_ready = 1'b1;
    @(negedge clk);
    chk("R4 single transfer", {31'd0, ks_valid}, 32'd0);
    get_byte(b);
    chk("R4 next byte", {24'd0, b}, {24'd0, model_out[1]});

    // R5: key write in the middle of the schedule is ignored
    pulse_start(5);
    repeat (1200) @(negedge clk);
    key_we = 1'b1; key_addr = 8'd250; key_data = 8'hEE;
    @(negedge clk);
    key_we = 1'b0;
    for (int n = 0; n < 4; n++) begin
      get_byte(b);
      chk($sformatf("R5 byte %0d", n), {24'd0, b}, {24'd0, model_out[n]});
    end

    // R6: start and key_len in the middle of the schedule are ignored
    pulse_start(5);
    repeat (1200) @(negedge clk);
    pulse_start(3);
    for (int n = 0; n < 4; n++) begin
      get_byte(b);
      chk($sformatf("R6 byte %0d", n), {24'd0, b}, {24'd0, model_out[n]});
    end

    // R7: restart during generation with a new key
    for (int a = 0; a < 3; a++) kbuf[a] = VKEY[1][63 - 8*a -: 8];
    write_key(3);
    pulse_start(3);
    chk("R7 valid low after restart", {31'd0, ks_valid}, 32'd0);
    for (int n = 0; n < 4; n++) begin
      get_byte(b);
      chk($sformatf("R7 byte %0d", n), {24'd0, b}, {24'd0, VEXP[1][31 - 8*n -: 8]});
    end

    // R9: one-byte key
    kbuf[0] = 8'hA5;
    write_key(1);
    pulse_start(1);
    ref_stream(1, 8);
    for (int n = 0; n < 8; n++) begin
      get_byte(b);
      chk($sformatf("R9 len1 byte %0d", n), {24'd0, b}, {24'd0, model_out[n]});
    end

    // R9: full 256-byte key
    for (int a = 0; a < 256; a++) kbuf[a] = 8'(a * 7 + 3);
    write_key(256);
    pulse_start(256);
    ref_stream(256, 8);
    for (int n = 0; n < 8; n++) begin
      get_byte(b);
      chk($sformatf("R9 len256 byte %0d", n), {24'd0, b}, {24'd0, model_out[n]});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule